// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block screens a DMA channel's transfer descriptor for illegal field combinations before the channel is serviced. It also captures bus errors reported by the data mover. The result is one error record. The record holds one flag per error kind, a valid bit and the number of the channel that caused the error. The data mover, the bus interface and the descriptor store sit outside the block. They present the descriptor fields, strobes and a channel number to the checker.

Each rule is evaluated combinationally in the cycle its trigger is high. The outcome is registered on the next clock edge. Only the most recent error is kept. Whenever a cycle raises at least one error, every flag is rewritten with that cycle's results and the channel field is replaced. A clear pulse empties the record.

Top module: `dma_desc_err_check`

## Requirements
- R1: When `check_i` is high, `err_nbytes_o` is set if `nbytes_i` is not a whole multiple of both the source and the destination transfer size. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 16 bytes.
- R2: When `check_i` is high, a source or destination size code in the range 4 to 7 sets `err_nbytes_o`.
- R3: When `check_i` is high and `citer_i` equals zero, `err_count_o` is set.
- R4: When `check_i` is high and `citer_link_i` differs from `biter_link_i`, `err_link_o` is set.
- R5: When `sg_check_i` and `sg_en_i` are both high and `sg_addr_i` is not a multiple of 32 (any of bits 4..0 set), `err_sg_o` is set. With `sg_en_i` low, the address is not checked.
- R6: `src_berr_i` sets `err_src_o`, and `dst_berr_i` sets `err_dst_o`.
- R7: Results appear on the outputs at the first clock edge after the trigger cycle and not before. Descriptor fields have no effect while `check_i` is low.
- R8: A cycle that raises any error replaces all six flags with exactly that cycle's errors. It loads `err_chan_o` from `chan_i` and sets `err_valid_o`. Several errors raised in one cycle are all set together.
- R9: Cycles that raise no error leave the flags, the channel and the valid bit unchanged. `err_valid_o` stays set until cleared.
- R10: `clear_i` zeroes the whole record on the next edge. An error raised in the same cycle as `clear_i` takes priority and is recorded.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_i | input | CHAN_W (2) | Channel number tied to this cycle's events |
| check_i | input | 1 | Evaluate the descriptor rules this cycle |
| nbytes_i | input | NBYTES_W (32) | Minor-loop byte count |
| src_size_i | input | 3 | Source transfer size code |
| dst_size_i | input | 3 | Destination transfer size code |
| citer_i | input | CITER_W (15) | Current major iteration count |
| citer_link_i | input | 1 | Link-enable bit of the current count |
| biter_link_i | input | 1 | Link-enable bit of the beginning count |
| sg_check_i | input | 1 | Scatter/gather step starts after major loop completion |
| sg_en_i | input | 1 | Scatter/gather enabled for this descriptor |
| sg_addr_i | input | ADDR_W (32) | Next-descriptor address for scatter/gather |
| src_berr_i | input | 1 | Source read returned a bus error |
| dst_berr_i | input | 1 | Destination write returned a bus error |
| clear_i | input | 1 | Clear the error record |
| err_nbytes_o | output | 1 | Byte count / size code error |
| err_count_o | output | 1 | Zero iteration count error |
| err_link_o | output | 1 | Link-bit mismatch error |
| err_sg_o | output | 1 | Scatter/gather address alignment error |
| err_src_o | output | 1 | Source bus error |
| err_dst_o | output | 1 | Destination bus error |
| err_valid_o | output | 1 | Record holds an error |
| err_chan_o | output | CHAN_W (2) | Channel of the recorded error |

## Verification
Every result of this block is due exactly one clock edge after the cycle in which its trigger or strobe was high. This holds for the descriptor rules, the alignment rule, the bus error strobes and the clear. The bench changes inputs just after a falling edge. It samples once before the following rising edge, to confirm nothing has moved early, and once 1 ns after that edge, where the new record must be present. Cycles that should leave the record alone are checked with the same sampling point, against the value recorded by the previous scenario.

// File: rtl/dma_desc_err_pkg.sv
package dma_desc_err_pkg;

    typedef struct packed {
        logic nbytes;
        logic count;
        logic link;
        logic sg;
        logic src;
        logic dst;
    } err_flags_t;

    localparam int SIZE_CODE_W = 3;

    // Low-order byte-count bits that must be zero for a given size code.
    function automatic logic [3:0] size_mask(input logic [SIZE_CODE_W-1:0] code);
        logic [3:0] m;
        case (code)
            3'd0:    m = 4'b0000;
            3'd1:    m = 4'b0001;
            3'd2:    m = 4'b0011;
            3'd3:    m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

    function automatic logic size_code_legal(input logic [SIZE_CODE_W-1:0] code);
        return (code <= 3'd3);
    endfunction

endpackage

// File: rtl/dma_size_rule.sv
module dma_size_rule
    import dma_desc_err_pkg::*;
#(
    parameter int NBYTES_W = 32
) (
    input  logic [SIZE_CODE_W-1:0] code_i,
    input  logic [NBYTES_W-1:0]    nbytes_i,
    output logic                   bad_o
);
    logic [3:0] mask;
    logic       misfit;

    always_comb begin
        mask   = size_mask(code_i);
        misfit = |(nbytes_i[3:0] & mask);
        bad_o  = misfit || !size_code_legal(code_i);
    end
endmodule

// File: rtl/dma_count_rule.sv
module dma_count_rule #(
    parameter int CITER_W = 15
) (
    input  logic               check_i,
    input  logic [CITER_W-1:0] citer_i,
    input  logic               citer_link_i,
    input  logic               biter_link_i,
    output logic               count_bad_o,
    output logic               link_bad_o
);
    always_comb begin
        count_bad_o = check_i && (citer_i == '0);
        link_bad_o  = check_i && (citer_link_i != biter_link_i);
    end
endmodule

// File: rtl/dma_sg_rule.sv
module dma_sg_rule #(
    parameter int ADDR_W   = 32,
    parameter int SG_ALIGN = 32
) (
    input  logic              sg_check_i,
    input  logic              sg_en_i,
    input  logic [ADDR_W-1:0] sg_addr_i,
    output logic              sg_bad_o
);
    localparam int ALIGN_BITS = $clog2(SG_ALIGN);

    always_comb begin
        sg_bad_o = sg_check_i && sg_en_i && (sg_addr_i[ALIGN_BITS-1:0] != '0);
    end
endmodule

// File: rtl/dma_err_record.sv
module dma_err_record
    import dma_desc_err_pkg::*;
#(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  err_flags_t        new_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              clear_i,
    output err_flags_t        flags_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              valid_o
);
    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        err_flags_t        flags;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (new_i != '0) begin
            rec_d.valid = 1'b1;
            rec_d.chan  = chan_i;
            rec_d.flags = new_i;
        end else if (clear_i) begin
            rec_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign flags_o = rec_q.flags;
    assign chan_o  = rec_q.chan;
    assign valid_o = rec_q.valid;
endmodule

// File: rtl/dma_desc_err_check.sv
module dma_desc_err_check
    import dma_desc_err_pkg::*;
#(
    parameter int CHAN_W   = 2,
    parameter int NBYTES_W = 32,
    parameter int CITER_W  = 15,
    parameter int ADDR_W   = 32,
    parameter int SG_ALIGN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CHAN_W-1:0]      chan_i,
    input  logic                   check_i,
    input  logic [NBYTES_W-1:0]    nbytes_i,
    input  logic [SIZE_CODE_W-1:0] src_size_i,
    input  logic [SIZE_CODE_W-1:0] dst_size_i,
    input  logic [CITER_W-1:0]     citer_i,
    input  logic                   citer_link_i,
    input  logic                   biter_link_i,
    input  logic                   sg_check_i,
    input  logic                   sg_en_i,
    input  logic [ADDR_W-1:0]      sg_addr_i,
    input  logic                   src_berr_i,
    input  logic                   dst_berr_i,
    input  logic                   clear_i,
    output logic                   err_nbytes_o,
    output logic                   err_count_o,
    output logic                   err_link_o,
    output logic                   err_sg_o,
    output logic                   err_src_o,
    output logic                   err_dst_o,
    output logic                   err_valid_o,
    output logic [CHAN_W-1:0]      err_chan_o
);
    localparam int NUM_SIDES = 2;

    logic [SIZE_CODE_W-1:0] side_code [NUM_SIDES];
    logic [NUM_SIDES-1:0]   side_bad;
    logic                   count_bad, link_bad, sg_bad;
    err_flags_t             new_err, rec_flags;

    assign side_code[0] = src_size_i;
    assign side_code[1] = dst_size_i;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dma_size_rule #(.NBYTES_W(NBYTES_W)) u_size (
            .code_i   (side_code[s]),
            .nbytes_i (nbytes_i),
            .bad_o    (side_bad[s])
        );
    end

    dma_count_rule #(.CITER_W(CITER_W)) u_count (
        .check_i      (check_i),
        .citer_i      (citer_i),
        .citer_link_i (citer_link_i),
        .biter_link_i (biter_link_i),
        .count_bad_o  (count_bad),
        .link_bad_o   (link_bad)
    );

    dma_sg_rule #(.ADDR_W(ADDR_W), .SG_ALIGN(SG_ALIGN)) u_sg (
        .sg_check_i (sg_check_i),
        .sg_en_i    (sg_en_i),
        .sg_addr_i  (sg_addr_i),
        .sg_bad_o   (sg_bad)
    );

    always_comb begin
        new_err        = '0;
        new_err.nbytes = check_i && (|side_bad);
        new_err.count  = count_bad;
        new_err.link   = link_bad;
        new_err.sg     = sg_bad;
        new_err.src    = src_berr_i;
        new_err.dst    = dst_berr_i;
    end

    dma_err_record #(.CHAN_W(CHAN_W)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_i   (new_err),
        .chan_i  (chan_i),
        .clear_i (clear_i),
        .flags_o (rec_flags),
        .chan_o  (err_chan_o),
        .valid_o (err_valid_o)
    );

    assign err_nbytes_o = rec_flags.nbytes;
    assign err_count_o  = rec_flags.count;
    assign err_link_o   = rec_flags.link;
    assign err_sg_o     = rec_flags.sg;
    assign err_src_o    = rec_flags.src;
    assign err_dst_o    = rec_flags.dst;
endmodule

// File: rtl/dma_desc_err_sva.sv
module dma_desc_err_sva #(
    parameter int CHAN_W  = 2,
    parameter int CITER_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CHAN_W-1:0]  chan_i,
    input logic               check_i,
    input logic [CITER_W-1:0] citer_i,
    input logic               citer_link_i,
    input logic               biter_link_i,
    input logic               sg_check_i,
    input logic               sg_en_i,
    input logic               src_berr_i,
    input logic               dst_berr_i,
    input logic               clear_i,
    input logic               err_nbytes_o,
    input logic               err_count_o,
    input logic               err_link_o,
    input logic               err_sg_o,
    input logic               err_src_o,
    input logic               err_dst_o,
    input logic               err_valid_o,
    input logic [CHAN_W-1:0]  err_chan_o
);
    logic [5:0] flags;
    assign flags = {err_nbytes_o, err_count_o, err_link_o, err_sg_o, err_src_o, err_dst_o};

    assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && citer_i == '0) |=> (err_count_o && err_valid_o && err_chan_o == $past(chan_i)));

    assert_link_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && citer_link_i != biter_link_i) |=> err_link_o);

    assert_bus_errors_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_berr_i || dst_berr_i) |=> (err_src_o == $past(src_berr_i) && err_dst_o == $past(dst_berr_i)));

    assert_valid_matches_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o == (flags != '0));

    assert_hold_when_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!check_i && !(sg_check_i && sg_en_i) && !src_berr_i && !dst_berr_i && !clear_i)
        |=> ($stable(flags) && $stable(err_chan_o) && $stable(err_valid_o)));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !check_i && !sg_check_i && !src_berr_i && !dst_berr_i)
        |=> (flags == '0 && !err_valid_o && err_chan_o == '0));
endmodule

bind dma_desc_err_check dma_desc_err_sva #(.CHAN_W(CHAN_W), .CITER_W(CITER_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_i       (chan_i),
    .check_i      (check_i),
    .citer_i      (citer_i),
    .citer_link_i (citer_link_i),
    .biter_link_i (biter_link_i),
    .sg_check_i   (sg_check_i),
    .sg_en_i      (sg_en_i),
    .src_berr_i   (src_berr_i),
    .dst_berr_i   (dst_berr_i),
    .clear_i      (clear_i),
    .err_nbytes_o (err_nbytes_o),
    .err_count_o  (err_count_o),
    .err_link_o   (err_link_o),
    .err_sg_o     (err_sg_o),
    .err_src_o    (err_src_o),
    .err_dst_o    (err_dst_o),
    .err_valid_o  (err_valid_o),
    .err_chan_o   (err_chan_o)
);

// File: tb/test_dma_desc_err_check.sv
module test_dma_desc_err_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  chan_i;
    logic        check_i;
    logic [31:0] nbytes_i;
    logic [2:0]  src_size_i, dst_size_i;
    logic [14:0] citer_i;
    logic        citer_link_i, biter_link_i;
    logic        sg_check_i, sg_en_i;
    logic [31:0] sg_addr_i;
    logic        src_berr_i, dst_berr_i, clear_i;
    logic        err_nbytes_o, err_count_o, err_link_o, err_sg_o;
    logic        err_src_o, err_dst_o, err_valid_o;
    logic [1:0]  err_chan_o;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    dma_desc_err_check i_dma_desc_err_check (
        .clk(clk), .rst_n(rst_n), .chan_i(chan_i), .check_i(check_i),
        .nbytes_i(nbytes_i), .src_size_i(src_size_i), .dst_size_i(dst_size_i),
        .citer_i(citer_i), .citer_link_i(citer_link_i), .biter_link_i(biter_link_i),
        .sg_check_i(sg_check_i), .sg_en_i(sg_en_i), .sg_addr_i(sg_addr_i),
        .src_berr_i(src_berr_i), .dst_berr_i(dst_berr_i), .clear_i(clear_i),
        .err_nbytes_o(err_nbytes_o), .err_count_o(err_count_o), .err_link_o(err_link_o),
        .err_sg_o(err_sg_o), .err_src_o(err_src_o), .err_dst_o(err_dst_o),
        .err_valid_o(err_valid_o), .err_chan_o(err_chan_o)
    );

    // {valid, chan[1:0], nbytes, count, link, sg, src, dst}
    function automatic logic [8:0] outs();
        return {err_valid_o, err_chan_o, err_nbytes_o, err_count_o, err_link_o,
                err_sg_o, err_src_o, err_dst_o};
    endfunction

    function automatic logic [8:0] rec(input logic v, input logic [1:0] ch, input logic [5:0] f);
        return {v, ch, f};
    endfunction

    task automatic chk(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = outs();
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic defaults();
        chan_i = 2'd0; check_i = 1'b0; nbytes_i = 32'd64;
        src_size_i = 3'd2; dst_size_i = 3'd2; citer_i = 15'd4;
        citer_link_i = 1'b0; biter_link_i = 1'b0;
        sg_check_i = 1'b0; sg_en_i = 1'b0; sg_addr_i = 32'h0;
        src_berr_i = 1'b0; dst_berr_i = 1'b0; clear_i = 1'b0;
    endtask

    // Inputs were set after a falling edge; pass the rising edge, drop strobes.
    task automatic step();
        @(posedge clk);
        #1;
        check_i = 1'b0; sg_check_i = 1'b0; src_berr_i = 1'b0;
        dst_berr_i = 1'b0; clear_i = 1'b0;
    endtask

    task automatic desc_check(input logic [1:0] ch, input logic [31:0] nb,
                              input logic [2:0] ss, input logic [2:0] ds,
                              input logic [14:0] ci, input logic cl, input logic bl);
        @(negedge clk);
        chan_i = ch; check_i = 1'b1; nbytes_i = nb; src_size_i = ss;
        dst_size_i = ds; citer_i = ci; citer_link_i = cl; biter_link_i = bl;
        step();
    endtask

    task automatic t_reset();
        chk("R11 reset", rec(0, 0, 6'b000000));
    endtask

    task automatic t_clean();
        desc_check(0, 64, 2, 3, 4, 0, 0);
        chk("R1 clean descriptor", rec(0, 0, 6'b000000));
    endtask

    task automatic t_multiple();
        @(negedge clk);
        chan_i = 1; check_i = 1; nbytes_i = 6; src_size_i = 2; dst_size_i = 0;
        citer_i = 4; citer_link_i = 0; biter_link_i = 0;
        #1 chk("R7 not before edge", rec(0, 0, 6'b000000));
        step();
        chk("R1 6 bytes vs 4-byte source", rec(1, 1, 6'b100000));
        desc_check(2, 48, 3, 1, 4, 0, 0);
        chk("R1 48 bytes vs 16/2 legal, R9 hold", rec(1, 1, 6'b100000));
        desc_check(2, 40, 3, 1, 4, 0, 0);
        chk("R1 40 bytes vs 16-byte source", rec(1, 2, 6'b100000));
        desc_check(0, 2, 0, 1, 4, 0, 0);
        chk("R1 2 bytes vs 2-byte dest legal", rec(1, 2, 6'b100000));
        desc_check(0, 3, 0, 1, 4, 0, 0);
        chk("R1 3 bytes vs 2-byte dest", rec(1, 0, 6'b100000));
    endtask

    task automatic t_codes();
        desc_check(3, 64, 5, 2, 4, 0, 0);
        chk("R2 source code 5", rec(1, 3, 6'b100000));
        desc_check(1, 64, 2, 7, 4, 0, 0);
        chk("R2 dest code 7", rec(1, 1, 6'b100000));
    endtask

    task automatic t_count_link();
        desc_check(0, 64, 2, 2, 0, 0, 0);
        chk("R3 zero count replaces R8", rec(1, 0, 6'b010000));
        desc_check(1, 64, 2, 2, 4, 1, 0);
        chk("R4 link mismatch", rec(1, 1, 6'b001000));
        desc_check(2, 64, 2, 2, 4, 1, 1);
        chk("R4 link both set legal", rec(1, 1, 6'b001000));
    endtask

    task automatic sg_event(input logic [1:0] ch, input logic en, input logic [31:0] addr);
        @(negedge clk);
        chan_i = ch; sg_check_i = 1; sg_en_i = en; sg_addr_i = addr;
        step();
        sg_en_i = 0;
    endtask

    task automatic t_sg();
        sg_event(2, 1, 32'h1010);
        chk("R5 misaligned address", rec(1, 2, 6'b000100));
        sg_event(3, 1, 32'h1020);
        chk("R5 aligned address", rec(1, 2, 6'b000100));
        sg_event(3, 0, 32'h1004);
        chk("R5 disabled no check", rec(1, 2, 6'b000100));
    endtask

    task automatic t_bus();
        @(negedge clk); chan_i = 1; src_berr_i = 1; step();
        chk("R6 source bus error", rec(1, 1, 6'b000010));
        @(negedge clk); chan_i = 2; dst_berr_i = 1; step();
        chk("R6 dest bus error", rec(1, 2, 6'b000001));
        @(negedge clk); chan_i = 3; src_berr_i = 1; dst_berr_i = 1; step();
        chk("R6 R8 both bus errors", rec(1, 3, 6'b000011));
    endtask

    task automatic t_combo();
        @(negedge clk);
        chan_i = 2; check_i = 1; nbytes_i = 5; src_size_i = 1; dst_size_i = 0;
        citer_i = 0; citer_link_i = 0; biter_link_i = 1;
        sg_check_i = 1; sg_en_i = 1; sg_addr_i = 32'h8; dst_berr_i = 1;
        step();
        sg_en_i = 0;
        chk("R8 all together", rec(1, 2, 6'b111101));
    endtask

    task automatic t_ignore();
        @(negedge clk);
        chan_i = 0; check_i = 0; nbytes_i = 7; src_size_i = 6; dst_size_i = 3;
        citer_i = 0; citer_link_i = 1; biter_link_i = 0;
        step();
        chk("R7 fields ignored without check", rec(1, 2, 6'b111101));
        defaults();
        repeat (5) @(negedge clk);
        chk("R9 sticky over idle cycles", rec(1, 2, 6'b111101));
    endtask

    task automatic t_clear();
        @(negedge clk); clear_i = 1; step();
        chk("R10 clear", rec(0, 0, 6'b000000));
        @(negedge clk); chan_i = 1; clear_i = 1; src_berr_i = 1; step();
        chk("R10 error wins over clear", rec(1, 1, 6'b000010));
        @(negedge clk); chan_i = 3; clear_i = 1; step();
        chk("R10 clear again", rec(0, 0, 6'b000000));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_multiple();
        t_codes();
        t_count_link();
        t_sg();
        t_bus();
        t_combo();
        t_ignore();
        t_clear();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule